// File: doc/BRIEF.md
# Indirect Transfer Request Queue

This block sits between a flash controller's register file and its transfer engine. Software loads a start address and a byte count, then fires a trigger that marks the operation as a read or a write. The block copies those values into a small in-order queue. The head of the queue is the active operation and is presented to the transfer engine. When the engine reports completion, or software cancels an active write, the next queued operation moves up to the head and a one-cycle done pulse is raised. At most two operations may be outstanding. A further trigger is dropped and sets a sticky reject interrupt.

The block also steers incoming bus writes. A write whose address falls inside the indirect trigger window goes to the indirect path. A write outside the window goes to the direct path when direct mode is enabled, and otherwise gets an error response.

For an active indirect write, the block only lets data be flushed to flash once the SRAM fill level is above a programmable watermark. The final data of a transfer is always let through. A watermark of all ones turns this gating off.

Top module: `ind_xfer_queue`

## Requirements
- R1: After reset no operation is active (`op_valid`=0), `op_done`=0 and `reject_irq`=0.
- R2: A trigger accepted while the queue is empty captures `cfg_start_addr`, `cfg_byte_cnt` and `trig_is_write` (1 = write, 0 = read). These appear on `op_addr`, `op_count` and `op_is_write` with `op_valid`=1 one clock after the trigger cycle.
- R3: A second trigger taken while one operation is active is held back. When `eng_done` is sampled high, `op_done` is high for exactly the next cycle, and in that same cycle the held operation is presented on the op outputs.
- R4: A trigger that arrives while two operations are outstanding is discarded, and `reject_irq` is high from the next cycle. Occupancy is judged before any retirement in that cycle.
- R5: `reject_irq` stays high until a cycle with `irq_clear`=1. If a new reject arrives in the same cycle as the clear, the reject wins.
- R6: A `cancel` pulse while the active operation is a write retires it the same way `eng_done` does: a done pulse, then promotion of the held operation. A `cancel` while a read is active, or while the queue is idle, has no effect.
- R7: A bus write with `trig_base` <= address < `trig_base`+`trig_span` asserts `to_indirect` only.
- R8: A bus write outside the window with `direct_en`=1 asserts `to_direct` only.
- R9: A bus write outside the window with `direct_en`=0 asserts `bus_err` only.
- R10: `flush_go` is high only while an active write exists and either `sram_fill` > `wr_watermark` or `last_data`=1.
- R11: With `wr_watermark` all ones, `flush_go` follows the presence of an active write, whatever the fill level.
- R12: `eng_done` while the queue is empty produces no done pulse and no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start_addr | input | 32 | Start address register value |
| cfg_byte_cnt | input | 16 | Byte count register value |
| trig_valid | input | 1 | Trigger pulse for a new indirect operation |
| trig_is_write | input | 1 | Direction of the trigger: 1 = write |
| cancel | input | 1 | Cancel pulse for the active write |
| irq_clear | input | 1 | Write-one-to-clear for the reject interrupt |
| eng_done | input | 1 | Transfer engine finished the active operation |
| op_valid | output | 1 | An operation is active |
| op_is_write | output | 1 | Direction of the active operation |
| op_addr | output | 32 | Start address of the active operation |
| op_count | output | 16 | Byte count of the active operation |
| op_done | output | 1 | One-cycle pulse when an operation retires |
| reject_irq | output | 1 | Sticky reject interrupt |
| bus_wr_valid | input | 1 | Bus write request |
| bus_wr_addr | input | 32 | Bus write address |
| trig_base | input | 32 | Trigger window base address |
| trig_span | input | 32 | Trigger window size in bytes |
| direct_en | input | 1 | Direct access mode enable |
| to_indirect | output | 1 | Write routed to the indirect path |
| to_direct | output | 1 | Write routed to the direct path |
| bus_err | output | 1 | Error response for the write |
| sram_fill | input | 8 | SRAM fill level |
| wr_watermark | input | 8 | Write watermark level |
| last_data | input | 1 | Final data of the transfer is in SRAM |
| flush_go | output | 1 | Flushing to flash is allowed |

## Verification
The queue is driven with a single write, then a write followed by a read, then a third trigger while full. Running these in sequence shows whether ordering is kept and whether the overflow entry is truly dropped rather than overwriting the held one. Cancel is tried against an active read and against an active write, which separates direction-aware cancelling from a blind pop. The router is probed at both window edges and just past each of them, under both direct-mode settings. The flush gate is probed below, at and above the watermark, with the final-data flag, and with the all-ones watermark.

// File: rtl/ixq_pkg.sv
package ixq_pkg;
  localparam int IXQ_AW = 32;
  localparam int IXQ_CW = 16;
  localparam int IXQ_FW = 8;

  typedef struct packed {
    logic              wr;
    logic [IXQ_AW-1:0] addr;
    logic [IXQ_CW-1:0] cnt;
  } ixq_req_t;

  function automatic logic addr_in_window(input logic [IXQ_AW-1:0] a,
                                          input logic [IXQ_AW-1:0] base,
                                          input logic [IXQ_AW-1:0] span);
    logic [IXQ_AW:0] lim;
    lim = {1'b0, base} + {1'b0, span};
    return ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < lim);
  endfunction

  function automatic logic fill_passes(input logic [IXQ_FW-1:0] fill,
                                       input logic [IXQ_FW-1:0] mark,
                                       input logic last);
    return last || (&mark) || (fill > mark);
  endfunction
endpackage

// File: rtl/ixq_slot_queue.sv
module ixq_slot_queue
  import ixq_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  ixq_req_t         push_req,
  input  logic             pop,
  output ixq_req_t         head,
  output logic             head_valid,
  output logic             full,
  output logic [OCC_W-1:0] occ
);
  ixq_req_t         slot_q [DEPTH];
  logic [OCC_W-1:0] occ_q;
  logic             pop_ok;
  logic             push_ok;
  logic [OCC_W-1:0] wr_idx;

  assign full    = (occ_q == OCC_W'(DEPTH));
  assign pop_ok  = pop && (occ_q != '0);
  assign push_ok = push && !full;
  assign wr_idx  = occ_q - OCC_W'(pop_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_q + OCC_W'(push_ok) - OCC_W'(pop_ok);
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    ixq_req_t shifted;
    if (gi < DEPTH - 1) begin : g_mid
      assign shifted = pop_ok ? slot_q[gi+1] : slot_q[gi];
    end else begin : g_end
      assign shifted = slot_q[gi];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    slot_q[gi] <= '0;
      else if (push_ok && (wr_idx == OCC_W'(gi)))    slot_q[gi] <= push_req;
      else                                           slot_q[gi] <= shifted;
    end
  end

  assign head       = slot_q[0];
  assign head_valid = (occ_q != '0);
  assign occ        = occ_q;
endmodule

// File: rtl/ixq_write_router.sv
module ixq_write_router
  import ixq_pkg::*;
(
  input  logic              wr_valid,
  input  logic [IXQ_AW-1:0] wr_addr,
  input  logic [IXQ_AW-1:0] win_base,
  input  logic [IXQ_AW-1:0] win_span,
  input  logic              direct_en,
  output logic              in_window,
  output logic              to_indirect,
  output logic              to_direct,
  output logic              bus_err
);
  assign in_window   = addr_in_window(wr_addr, win_base, win_span);
  assign to_indirect = wr_valid && in_window;
  assign to_direct   = wr_valid && !in_window && direct_en;
  assign bus_err     = wr_valid && !in_window && !direct_en;
endmodule

// File: rtl/ixq_flush_gate.sv
module ixq_flush_gate
  import ixq_pkg::*;
(
  input  logic              active_write,
  input  logic [IXQ_FW-1:0] fill,
  input  logic [IXQ_FW-1:0] watermark,
  input  logic              last,
  output logic              flush_go
);
  assign flush_go = active_write && fill_passes(fill, watermark, last);
endmodule

// File: rtl/ind_xfer_queue.sv
module ind_xfer_queue
  import ixq_pkg::*;
#(
  parameter int QDEPTH = 2,
  localparam int OCC_W = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IXQ_AW-1:0] cfg_start_addr,
  input  logic [IXQ_CW-1:0] cfg_byte_cnt,
  input  logic              trig_valid,
  input  logic              trig_is_write,
  input  logic              cancel,
  input  logic              irq_clear,
  input  logic              eng_done,
  output logic              op_valid,
  output logic              op_is_write,
  output logic [IXQ_AW-1:0] op_addr,
  output logic [IXQ_CW-1:0] op_count,
  output logic              op_done,
  output logic              reject_irq,
  input  logic              bus_wr_valid,
  input  logic [IXQ_AW-1:0] bus_wr_addr,
  input  logic [IXQ_AW-1:0] trig_base,
  input  logic [IXQ_AW-1:0] trig_span,
  input  logic              direct_en,
  output logic              to_indirect,
  output logic              to_direct,
  output logic              bus_err,
  input  logic [IXQ_FW-1:0] sram_fill,
  input  logic [IXQ_FW-1:0] wr_watermark,
  input  logic              last_data,
  output logic              flush_go
);
  ixq_req_t         new_req;
  ixq_req_t         head;
  logic             head_valid;
  logic             q_full;
  logic [OCC_W-1:0] q_occ;
  logic             finish_evt;
  logic             reject_evt;
  logic             win_hit;
  logic             done_q;
  logic             irq_q;

  assign new_req    = '{wr: trig_is_write, addr: cfg_start_addr, cnt: cfg_byte_cnt};
  assign finish_evt = head_valid && (eng_done || (cancel && head.wr));
  assign reject_evt = trig_valid && q_full;

  ixq_slot_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(trig_valid), .push_req(new_req), .pop(finish_evt),
    .head(head), .head_valid(head_valid), .full(q_full), .occ(q_occ)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= finish_evt;
      if (reject_evt)     irq_q <= 1'b1;
      else if (irq_clear) irq_q <= 1'b0;
    end
  end

  assign op_valid    = head_valid;
  assign op_is_write = head_valid && head.wr;
  assign op_addr     = head.addr;
  assign op_count    = head.cnt;
  assign op_done     = done_q;
  assign reject_irq  = irq_q;

  ixq_write_router u_router (
    .wr_valid(bus_wr_valid), .wr_addr(bus_wr_addr),
    .win_base(trig_base), .win_span(trig_span), .direct_en(direct_en),
    .in_window(win_hit), .to_indirect(to_indirect),
    .to_direct(to_direct), .bus_err(bus_err)
  );

  ixq_flush_gate u_gate (
    .active_write(op_is_write), .fill(sram_fill), .watermark(wr_watermark),
    .last(last_data), .flush_go(flush_go)
  );
endmodule

// File: rtl/ixq_checker.sv
module ixq_checker
  import ixq_pkg::*;
#(
  parameter int QDEPTH = 2,
  localparam int OCC_W = $clog2(QDEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_valid,
  input logic             irq_clear,
  input logic             eng_done,
  input logic             op_valid,
  input logic             op_is_write,
  input logic             op_done,
  input logic             reject_irq,
  input logic             finish_evt,
  input logic [OCC_W-1:0] q_occ,
  input logic             to_indirect,
  input logic             to_direct,
  input logic             bus_err,
  input logic             flush_go
);
  assert_occ_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    q_occ <= OCC_W'(QDEPTH));

  assert_reject_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && q_occ == OCC_W'(QDEPTH)) |=> reject_irq);

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reject_irq && !irq_clear) |=> reject_irq);

  assert_done_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> op_done);

  assert_idle_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && eng_done) |=> !op_done);

  assert_route_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({to_indirect, to_direct, bus_err}));

  assert_flush_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_go |-> (op_valid && op_is_write));
endmodule

bind ind_xfer_queue ixq_checker #(.QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .irq_clear(irq_clear),
  .eng_done(eng_done), .op_valid(op_valid), .op_is_write(op_is_write),
  .op_done(op_done), .reject_irq(reject_irq), .finish_evt(finish_evt),
  .q_occ(q_occ), .to_indirect(to_indirect), .to_direct(to_direct),
  .bus_err(bus_err), .flush_go(flush_go)
);

// File: tb/ind_xfer_queue_test.sv
module ind_xfer_queue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_start_addr = '0;
  logic [15:0] cfg_byte_cnt = '0;
  logic        trig_valid = 1'b0, trig_is_write = 1'b0;
  logic        cancel = 1'b0, irq_clear = 1'b0, eng_done = 1'b0;
  logic        op_valid, op_is_write, op_done, reject_irq;
  logic [31:0] op_addr;
  logic [15:0] op_count;
  logic        bus_wr_valid = 1'b0;
  logic [31:0] bus_wr_addr = '0;
  logic [31:0] trig_base = 32'h100, trig_span = 32'h40;
  logic        direct_en = 1'b0;
  logic        to_indirect, to_direct, bus_err;
  logic [7:0]  sram_fill = '0, wr_watermark = 8'd16;
  logic        last_data = 1'b0;
  logic        flush_go;

  int total = 0;
  int bad = 0;

  typedef struct { logic wr; logic [31:0] addr; logic [15:0] cnt; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  ind_xfer_queue uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic trigger(input logic wr, input logic [31:0] a, input logic [15:0] c);
    @(negedge clk);
    cfg_start_addr = a; cfg_byte_cnt = c; trig_is_write = wr; trig_valid = 1'b1;
    if (exp_q.size() < 2) exp_q.push_back('{wr, a, c});
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  // monitor: compare the active op with the scoreboard head
  task automatic compare_head(input string req);
    if (exp_q.size() == 0) check(req, {63'b0, op_valid}, 64'd0);
    else begin
      check(req, {63'b0, op_valid}, 64'd1);
      check(req, {63'b0, op_is_write}, {63'b0, exp_q[0].wr});
      check(req, {32'b0, op_addr}, {32'b0, exp_q[0].addr});
      check(req, {48'b0, op_count}, {48'b0, exp_q[0].cnt});
    end
  endtask

  task automatic retire(input logic by_cancel, input string req);
    @(negedge clk);
    if (by_cancel) cancel = 1'b1; else eng_done = 1'b1;
    if (exp_q.size() > 0) void'(exp_q.pop_front());
    @(negedge clk);
    cancel = 1'b0; eng_done = 1'b0;
    check(req, {63'b0, op_done}, 64'd1);
    compare_head(req);
    @(negedge clk);
    check(req, {63'b0, op_done}, 64'd0);
  endtask

  task automatic route(input logic [31:0] a, input logic den, input logic [2:0] exp, input string req);
    bus_wr_valid = 1'b1; bus_wr_addr = a; direct_en = den;
    #1;
    check(req, {61'b0, to_indirect, to_direct, bus_err}, {61'b0, exp});
    bus_wr_valid = 1'b0;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {61'b0, op_valid, op_done, reject_irq}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    trigger(1'b1, 32'h1000, 16'd64);
    compare_head("R2");
    trigger(1'b0, 32'h2000, 16'd8);
    compare_head("R3");
    check("R4", {63'b0, reject_irq}, 64'd0);
    trigger(1'b1, 32'h3000, 16'd4);   // third: dropped
    check("R4", {63'b0, reject_irq}, 64'd1);
    compare_head("R4");

    // flush gating with active write
    sram_fill = 8'd16; wr_watermark = 8'd16; last_data = 1'b0; #1;
    check("R10", {63'b0, flush_go}, 64'd0);
    sram_fill = 8'd17; #1;
    check("R10", {63'b0, flush_go}, 64'd1);
    sram_fill = 8'd3; last_data = 1'b1; #1;
    check("R10", {63'b0, flush_go}, 64'd1);
    last_data = 1'b0; wr_watermark = 8'hFF; sram_fill = 8'd0; #1;
    check("R11", {63'b0, flush_go}, 64'd1);

    retire(1'b0, "R3");               // write done -> read active
    check("R10", {63'b0, flush_go}, 64'd0);
    check("R5", {63'b0, reject_irq}, 64'd1);
    irq_clear = 1'b1; @(negedge clk); irq_clear = 1'b0;
    check("R5", {63'b0, reject_irq}, 64'd0);

    // cancel against a read: ignored
    cancel = 1'b1; @(negedge clk); cancel = 1'b0;
    check("R6", {63'b0, op_done}, 64'd0);
    compare_head("R6");
    retire(1'b0, "R4");               // queue now empty: third was dropped
    check("R4", {63'b0, op_valid}, 64'd0);

    eng_done = 1'b1; cancel = 1'b1; @(negedge clk); eng_done = 1'b0; cancel = 1'b0;
    check("R12", {62'b0, op_done, op_valid}, 64'd0);

    trigger(1'b1, 32'h4000, 16'd128);
    trigger(1'b0, 32'h5000, 16'd16);
    retire(1'b1, "R6");               // cancel active write -> read promoted
    retire(1'b0, "R3");

    // reject and clear in same cycle: reject wins
    trigger(1'b1, 32'h6000, 16'd1);
    trigger(1'b1, 32'h7000, 16'd2);
    @(negedge clk);
    trig_valid = 1'b1; irq_clear = 1'b1;
    @(negedge clk);
    trig_valid = 1'b0; irq_clear = 1'b0;
    check("R5", {63'b0, reject_irq}, 64'd1);
    retire(1'b0, "R3");
    retire(1'b0, "R3");

    route(32'h100, 1'b0, 3'b100, "R7");
    route(32'h13F, 1'b1, 3'b100, "R7");
    route(32'h140, 1'b1, 3'b010, "R8");
    route(32'h0FF, 1'b1, 3'b010, "R8");
    route(32'h140, 1'b0, 3'b001, "R9");
    route(32'h0FF, 1'b0, 3'b001, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule